// File: doc/BRIEF.md
# DDR Command Bus Decoder and Bank Rule Checker

This block sits passively on the command bus of a DDR SDRAM channel. It samples one command on each rising clock edge. The command is formed from chip select, row strobe, column strobe, write enable, clock enable, the bank-select bits and address bit 10. The block classifies the command into a compact code and keeps a model of which banks hold an open row. It also keeps cycle counters that measure how far apart related commands were issued.

Two kinds of problems are reported. The first is a command that the current bank state does not allow. The second is a command that arrives too soon after an earlier one. Every command still updates the bank model, even when it is flagged, so that later checks stay aligned with the device it mirrors. All minimum spacings and the auto-precharge delay are parameters, so other speed grades can be checked with the same logic.

Top module: `dram_cmd_checker`

## Requirements
- R1: While reset is high and on the cycle after it, `cmd_o` reads 0, both flags read 0 and every bank reads idle.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} is decoded as follows: 011 gives ACTIVATE (code 2), 111 gives NOP (code 1), 110 gives BURST STOP (code 13), 101 gives READ (code 3), 100 gives WRITE (code 4), 010 gives PRECHARGE (code 5) and 000 gives MODE SET (code 9).
- R3: When `cs_n` is high the command is a deselect (code 0), whatever the levels on the other inputs.
- R4: Several commands have variants. With `a10` high, READ becomes code 7, WRITE becomes code 8 and PRECHARGE becomes precharge-all (code 6). A mode set with `ba[0]` high becomes an extended mode set (code 10). The refresh pattern 001 gives auto refresh (code 11) when `cke` is high and self-refresh entry (code 12) when `cke` is low.
- R5: ACTIVATE to an idle bank opens it. PRECHARGE closes the addressed bank. Precharge-all closes every bank. A PRECHARGE to a bank that is already idle changes neither its state nor its precharge timing.
- R6: A READ or WRITE with `a10` high, issued to an open bank, closes that bank AP_DELAY cycles after the command edge. Its precharge spacing is measured from that point.
- R7: A READ or WRITE to an idle bank, or an ACTIVATE to an open bank, raises `illegal_o`. An illegal ACTIVATE leaves the bank state and its activate timing unchanged.
- R8: A mode set or extended mode set issued while any bank is open raises `illegal_o`.
- R9: `timing_o` is raised on a same-bank spacing violation, measured in cycles between command edges. The rules are: ACTIVATE to READ fewer than T_RCD_RD cycles, ACTIVATE to WRITE fewer than T_RCD_WR, close to ACTIVATE fewer than T_RP, ACTIVATE to ACTIVATE fewer than T_RC, and ACTIVATE to PRECHARGE (or precharge-all, for each open bank) fewer than T_RAS. The command still takes effect.
- R10: `timing_o` is also raised for an ACTIVATE fewer than T_RRD cycles after the previous ACTIVATE to any bank. It is raised as well for a mode set fewer than T_MRD cycles after the previous mode set of either kind.
- R11: The command code and both flags for a command appear on the outputs after the clock edge that samples it. `bank_active_o` shows the bank state after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Address bit 10 (precharge-all / auto-precharge) |
| cmd_o | output | 4 | Decoded command code |
| bank_active_o | output | 2**BA_W | Per-bank open-row state |
| illegal_o | output | 1 | Command not allowed in current bank state |
| timing_o | output | 1 | Minimum spacing violated |

## Verification
The bench uses the default parameters: four banks, T_RCD_RD=4, T_RCD_WR=2, T_RP=4, T_RAS=9, T_RC=13, T_RRD=3, T_MRD=2 and AP_DELAY=4. These values are small enough that each spacing rule can be placed exactly on its limit and one cycle short of it within a few dozen cycles. This covers a precharge landing at gap 5 against T_RAS, and a reopen at exactly T_RC and T_RP after the last activate and the close. An auto-precharge delay of four cycles lets the bench watch the bank close on a precise cycle. It can then also see a reopen flagged against the precharge spacing that starts at that implicit close.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_PREA  = 4'd6,
        CMD_RDA   = 4'd7,
        CMD_WRA   = 4'd8,
        CMD_MRS   = 4'd9,
        CMD_EMRS  = 4'd10,
        CMD_REF   = 4'd11,
        CMD_SREF  = 4'd12,
        CMD_BST   = 4'd13
    } cmd_e;

    typedef struct packed {
        logic ill;
        logic tim;
    } verdict_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_col_rd(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_RDA);
    endfunction

    function automatic logic is_col_wr(input cmd_e c);
        return (c == CMD_WR) || (c == CMD_WRA);
    endfunction

    function automatic logic is_modeset(input cmd_e c);
        return (c == CMD_MRS) || (c == CMD_EMRS);
    endfunction

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n,
                                        input logic cke, input logic a10,
                                        input logic bs0);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b010:  c = a10 ? CMD_PREA : CMD_PRE;
                3'b101:  c = a10 ? CMD_RDA : CMD_RD;
                3'b100:  c = a10 ? CMD_WRA : CMD_WR;
                3'b000:  c = bs0 ? CMD_EMRS : CMD_MRS;
                3'b001:  c = cke ? CMD_REF : CMD_SREF;
                3'b110:  c = CMD_BST;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dcc_decode.sv
module dcc_decode
    import dcc_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output cmd_e            cmd
);
    always_comb begin
        cmd = decode_cmd(cs_n, ras_n, cas_n, we_n, cke, a10, ba[0]);
    end
endmodule

// File: rtl/dcc_bank.sv
module dcc_bank
    import dcc_pkg::*;
#(
    parameter int CW       = 4,
    parameter int T_RCD_RD = 4,
    parameter int T_RCD_WR = 2,
    parameter int T_RP     = 4,
    parameter int T_RAS    = 9,
    parameter int T_RC     = 13,
    parameter int AP_DELAY = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sel,
    input  cmd_e     cmd,
    output logic     active_o,
    output verdict_t verdict_o
);
    localparam int              APW    = $clog2(AP_DELAY + 1);
    localparam logic [CW-1:0]   SAT    = '1;
    localparam logic [CW-1:0]   LIM_RD = CW'(T_RCD_RD);
    localparam logic [CW-1:0]   LIM_WR = CW'(T_RCD_WR);
    localparam logic [CW-1:0]   LIM_RP = CW'(T_RP);
    localparam logic [CW-1:0]   LIM_RS = CW'(T_RAS);
    localparam logic [CW-1:0]   LIM_RC = CW'(T_RC);
    localparam logic [APW-1:0]  AP_LD  = APW'(AP_DELAY);

    logic            active_q;
    logic [CW-1:0]   act_cnt;
    logic [CW-1:0]   pre_cnt;
    logic            ap_pend;
    logic [APW-1:0]  ap_cnt;

    logic rd, wr, act, auto_pre, pre_hit, ap_fire;

    always_comb begin
        rd       = sel && is_col_rd(cmd);
        wr       = sel && is_col_wr(cmd);
        act      = sel && (cmd == CMD_ACT);
        auto_pre = (cmd == CMD_RDA) || (cmd == CMD_WRA);
        pre_hit  = (sel && (cmd == CMD_PRE)) || (cmd == CMD_PREA);
        ap_fire  = ap_pend && (ap_cnt == APW'(1));

        verdict_o.ill = ((rd || wr) && !active_q) || (act && active_q);
        verdict_o.tim = (rd && active_q && (act_cnt < LIM_RD))
                     || (wr && active_q && (act_cnt < LIM_WR))
                     || (act && !active_q && ((pre_cnt < LIM_RP) || (act_cnt < LIM_RC)))
                     || (pre_hit && active_q && (act_cnt < LIM_RS));
        active_o = active_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            act_cnt  <= SAT;
            pre_cnt  <= SAT;
            ap_pend  <= 1'b0;
            ap_cnt   <= '0;
        end else begin
            act_cnt <= (act_cnt == SAT) ? SAT : act_cnt + 1'b1;
            pre_cnt <= (pre_cnt == SAT) ? SAT : pre_cnt + 1'b1;
            if (ap_pend) begin
                ap_cnt <= ap_cnt - 1'b1;
            end
            if (act && !active_q) begin
                active_q <= 1'b1;
                act_cnt  <= CW'(1);
            end else if (active_q && (pre_hit || ap_fire)) begin
                active_q <= 1'b0;
                pre_cnt  <= CW'(1);
                ap_pend  <= 1'b0;
            end else if ((rd || wr) && auto_pre && active_q) begin
                ap_pend <= 1'b1;
                ap_cnt  <= AP_LD;
            end
        end
    end
endmodule

// File: rtl/dcc_spacing.sv
module dcc_spacing
    import dcc_pkg::*;
#(
    parameter int CW    = 4,
    parameter int T_RRD = 3,
    parameter int T_MRD = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  cmd_e     cmd,
    output verdict_t verdict_o
);
    localparam logic [CW-1:0] SAT     = '1;
    localparam logic [CW-1:0] LIM_RRD = CW'(T_RRD);
    localparam logic [CW-1:0] LIM_MRD = CW'(T_MRD);

    logic [CW-1:0] rrd_cnt;
    logic [CW-1:0] mrd_cnt;
    logic          is_act, is_ms;

    always_comb begin
        is_act        = (cmd == CMD_ACT);
        is_ms         = is_modeset(cmd);
        verdict_o.ill = 1'b0;
        verdict_o.tim = (is_act && (rrd_cnt < LIM_RRD)) || (is_ms && (mrd_cnt < LIM_MRD));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rrd_cnt <= SAT;
            mrd_cnt <= SAT;
        end else begin
            rrd_cnt <= is_act ? CW'(1) : ((rrd_cnt == SAT) ? SAT : rrd_cnt + 1'b1);
            mrd_cnt <= is_ms  ? CW'(1) : ((mrd_cnt == SAT) ? SAT : mrd_cnt + 1'b1);
        end
    end
endmodule

// File: rtl/dram_cmd_checker.sv
module dram_cmd_checker
    import dcc_pkg::*;
#(
    parameter int BA_W     = 2,
    parameter int T_RCD_RD = 4,
    parameter int T_RCD_WR = 2,
    parameter int T_RP     = 4,
    parameter int T_RAS    = 9,
    parameter int T_RC     = 13,
    parameter int T_RRD    = 3,
    parameter int T_MRD    = 2,
    parameter int AP_DELAY = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   cke,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic [3:0]             cmd_o,
    output logic [(1<<BA_W)-1:0]   bank_active_o,
    output logic                   illegal_o,
    output logic                   timing_o
);
    localparam int NB     = 1 << BA_W;
    localparam int LIMMAX = max_i(max_i(max_i(T_RCD_RD, T_RCD_WR), max_i(T_RP, T_RAS)),
                                  max_i(max_i(T_RC, T_RRD), T_MRD));
    localparam int CW     = $clog2(LIMMAX + 1);

    cmd_e     cmd;
    verdict_t bank_v [NB];
    verdict_t glob_v;
    logic [NB-1:0] bank_ill, bank_tim;

    dcc_decode #(.BA_W(BA_W)) u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .a10(a10), .cmd(cmd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        dcc_bank #(
            .CW(CW), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR), .T_RP(T_RP),
            .T_RAS(T_RAS), .T_RC(T_RC), .AP_DELAY(AP_DELAY)
        ) u_bank (
            .clk(clk), .rst(rst),
            .sel(ba == BA_W'(i)),
            .cmd(cmd),
            .active_o(bank_active_o[i]),
            .verdict_o(bank_v[i])
        );
        assign bank_ill[i] = bank_v[i].ill;
        assign bank_tim[i] = bank_v[i].tim;
    end

    dcc_spacing #(.CW(CW), .T_RRD(T_RRD), .T_MRD(T_MRD)) u_space (
        .clk(clk), .rst(rst), .cmd(cmd), .verdict_o(glob_v)
    );

    logic ill_d, tim_d;
    always_comb begin
        ill_d = (|bank_ill) || glob_v.ill || (is_modeset(cmd) && (|bank_active_o));
        tim_d = (|bank_tim) || glob_v.tim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o     <= CMD_DESEL;
            illegal_o <= 1'b0;
            timing_o  <= 1'b0;
        end else begin
            cmd_o     <= cmd;
            illegal_o <= ill_d;
            timing_o  <= tim_d;
        end
    end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int BA_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BA_W-1:0]      ba,
    input logic [3:0]           cmd_o,
    input logic [(1<<BA_W)-1:0] bank_active_o,
    input logic                 illegal_o,
    input logic                 timing_o
);
    logic ms_in, col_in, live;
    assign ms_in  = !cs_n && !ras_n && !cas_n && !we_n;
    assign col_in = !cs_n && ras_n && !cas_n;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_o == 4'd0));                                     // R3

    AST_PREA_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'd6) |-> (bank_active_o == '0));                    // R5

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'd2 && !illegal_o) |-> (bank_active_o != '0));      // R5

    AST_COL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (col_in && !bank_active_o[ba]) |=> illegal_o);                 // R7

    AST_MODESET_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ms_in && (|bank_active_o)) |=> illegal_o);                    // R8

    AST_MODESET_GAP: assert property (@(posedge clk) disable iff (rst)
        (live && ms_in && $past(ms_in)) |=> timing_o);                 // R10
endmodule

bind dram_cmd_checker dcc_checker #(.BA_W(BA_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .cmd_o(cmd_o), .bank_active_o(bank_active_o),
    .illegal_o(illegal_o), .timing_o(timing_o)
);

// File: tb/dram_cmd_checker_tb.sv
module dram_cmd_checker_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_o;
    logic [3:0] bank_active_o;
    logic       illegal_o, timing_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] cmd;
        logic       ill;
        logic       tim;
        logic [3:0] mask;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    dram_cmd_checker u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_o),
        .bank_active_o(bank_active_o), .illegal_o(illegal_o), .timing_o(timing_o)
    );

    task automatic issue(input logic csn, input logic [2:0] rcw, input logic k,
                         input logic [1:0] b, input logic ap, input logic [3:0] ec,
                         input logic ei, input logic et, input logic [3:0] em,
                         input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = csn; {ras_n, cas_n, we_n} = rcw; cke = k; ba = b; a10 = ap;
        e.cmd = ec; e.ill = ei; e.tim = et; e.mask = em; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic nop(input logic [3:0] em, input string tag);
        issue(1'b0, 3'b111, 1'b1, 2'd0, 1'b0, 4'd1, 1'b0, 1'b0, em, tag);
    endtask

    // monitor: compare one queued expectation per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (cmd_o !== e.cmd || illegal_o !== e.ill || timing_o !== e.tim ||
                    bank_active_o !== e.mask) begin
                    n_fail++;
                    $display("FAIL %s: got cmd=%0d ill=%b tim=%b banks=%b, expected cmd=%0d ill=%b tim=%b banks=%b",
                             e.tag, cmd_o, illegal_o, timing_o, bank_active_o,
                             e.cmd, e.ill, e.tim, e.mask);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog: got hung run, expected completion");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (cmd_o !== 4'd0 || illegal_o !== 1'b0 || timing_o !== 1'b0 || bank_active_o !== 4'b0) begin
            n_fail++;
            $display("FAIL R1: got cmd=%0d ill=%b tim=%b banks=%b, expected 0 0 0 0000",
                     cmd_o, illegal_o, timing_o, bank_active_o);
        end
        rst = 1'b0;
        nop(4'b0000, "R1 first NOP after reset");
        issue(1'b1, 3'b000, 1'b1, 2'd3, 1'b1, 4'd0, 0, 0, 4'b0000, "R3 deselect");
        issue(1'b0, 3'b110, 1'b1, 2'd0, 1'b0, 4'd13, 0, 0, 4'b0000, "R2 burst stop");
        issue(1'b0, 3'b000, 1'b1, 2'd0, 1'b0, 4'd9, 0, 0, 4'b0000, "R2 mode set");
        issue(1'b0, 3'b000, 1'b1, 2'd1, 1'b0, 4'd10, 0, 1, 4'b0000, "R4 R10 ext mode set too soon");
        nop(4'b0000, "R2 nop");
        issue(1'b0, 3'b000, 1'b1, 2'd0, 1'b0, 4'd9, 0, 0, 4'b0000, "R10 mode set at gap 2");
        issue(1'b0, 3'b001, 1'b1, 2'd0, 1'b0, 4'd11, 0, 0, 4'b0000, "R4 auto refresh");
        issue(1'b0, 3'b001, 1'b0, 2'd0, 1'b0, 4'd12, 0, 0, 4'b0000, "R4 self refresh entry");
        issue(1'b0, 3'b101, 1'b1, 2'd0, 1'b0, 4'd3, 1, 0, 4'b0000, "R7 read idle bank");
        issue(1'b0, 3'b011, 1'b1, 2'd0, 1'b0, 4'd2, 0, 0, 4'b0001, "R5 R11 activate bank0");
        issue(1'b0, 3'b011, 1'b1, 2'd1, 1'b0, 4'd2, 0, 1, 4'b0011, "R10 act-act other bank gap 1");
        issue(1'b0, 3'b100, 1'b1, 2'd0, 1'b0, 4'd4, 0, 0, 4'b0011, "R9 write at gap 2");
        issue(1'b0, 3'b101, 1'b1, 2'd0, 1'b0, 4'd3, 0, 1, 4'b0011, "R9 read at gap 3");
        issue(1'b0, 3'b101, 1'b1, 2'd0, 1'b0, 4'd3, 0, 0, 4'b0011, "R9 read at gap 4");
        issue(1'b0, 3'b010, 1'b1, 2'd0, 1'b0, 4'd5, 0, 1, 4'b0010, "R9 precharge at gap 5");
        issue(1'b0, 3'b011, 1'b1, 2'd0, 1'b0, 4'd2, 0, 1, 4'b0011, "R9 reopen one cycle after close");
        nop(4'b0011, "R2 nop");
        nop(4'b0011, "R2 nop");
        issue(1'b0, 3'b011, 1'b1, 2'd0, 1'b0, 4'd2, 1, 0, 4'b0011, "R7 activate open bank");
        issue(1'b0, 3'b010, 1'b1, 2'd2, 1'b1, 4'd6, 0, 1, 4'b0000, "R5 R9 precharge all");
        nop(4'b0000, "R2 nop");
        nop(4'b0000, "R2 nop");
        nop(4'b0000, "R2 nop");
        issue(1'b0, 3'b011, 1'b1, 2'd1, 1'b0, 4'd2, 0, 0, 4'b0010, "R9 reopen at exact limits");
        issue(1'b0, 3'b000, 1'b1, 2'd0, 1'b0, 4'd9, 1, 0, 4'b0010, "R8 mode set with open bank");
        issue(1'b0, 3'b100, 1'b1, 2'd1, 1'b1, 4'd8, 0, 0, 4'b0010, "R4 R6 write auto-precharge");
        nop(4'b0010, "R6 still open +1");
        nop(4'b0010, "R6 still open +2");
        nop(4'b0010, "R6 still open +3");
        nop(4'b0000, "R6 closed at +4");
        issue(1'b0, 3'b011, 1'b1, 2'd1, 1'b0, 4'd2, 0, 1, 4'b0010, "R6 R9 reopen after auto close");
        issue(1'b0, 3'b010, 1'b1, 2'd3, 1'b0, 4'd5, 0, 0, 4'b0010, "R5 precharge idle bank");
        nop(4'b0010, "R2 nop");
        issue(1'b0, 3'b011, 1'b1, 2'd3, 1'b0, 4'd2, 0, 0, 4'b1010, "R5 idle precharge left timing alone");
        issue(1'b0, 3'b101, 1'b1, 2'd3, 1'b1, 4'd7, 0, 1, 4'b1010, "R4 R9 read auto-precharge at gap 1");
        nop(4'b1010, "R6 read ap +1");
        nop(4'b1010, "R6 read ap +2");
        nop(4'b1010, "R6 read ap +3");
        nop(4'b0010, "R6 read ap closed +4");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule